// File: doc/BRIEF.md
# Bridge Control I/O Routing Logic

This block holds the 16-bit control word of a root-port bridge and applies it to the traffic the port sees. For every processor I/O address presented on its input it decides, combinationally, whether the access is sent downstream. An address is sent when it falls inside the I/O window given by a base and a limit of 4 KB granularity. When legacy ISA exclusion is on, any address in the window whose offset in its 1 KB block lands in the upper 768 bytes is held back. When legacy display routing is on, the display I/O ranges 0x3B0–0x3BB and 0x3C0–0x3DF are sent regardless of the window. They are matched on the low ten address bits, so every 1 KB alias also matches, or on all sixteen bits when the full-decode option is set.

The same control word gates error messages arriving from downstream into a one-cycle system-error pulse. It also decides whether a poisoned read completion may set a sticky parity-error status flag, which software clears by writing one. A control bit requests a hot reset of the link for as long as it stays set, provided the link is in an active or low-power state. A small register port reads and writes the control and status words.

Top module: `brc_io_router`

## Requirements
- R1: After reset the control word (reg_sel=0) and the status word (reg_sel=1) read 0. Only control bits 0,1,2,3,4,6 are writable; bit 5 and bits 15:7 always read 0.
- R2: With control bit 2 at 0, an address A is forwarded when {win_base_hi,12'h000} <= A <= {win_limit_hi,12'hFFF}, both ends inclusive, and not forwarded outside that range.
- R3: When win_base_hi is greater than win_limit_hi the window is empty and no address is forwarded through it; equal values give one 4 KB window.
- R4: With control bit 2 at 1, an address inside the window whose bits [9:8] are nonzero is not forwarded; bits [9:8] equal to 0 still forward. Addresses outside the window stay unforwarded.
- R5: With control bit 3 at 0, display I/O addresses are forwarded only through the window rule.
- R6: With control bit 3 at 1 and bit 4 at 0, any address whose bits [9:0] fall in 0x3B0–0x3BB or 0x3C0–0x3DF is forwarded, aliases included, even when empty window or ISA exclusion would block it.
- R7: With control bits 3 and 4 both at 1, only addresses 0x03B0–0x03BB and 0x03C0–0x03DF match the display ranges; aliases do not.
- R8: Control bit 4 has no effect while control bit 3 is 0.
- R9: A message on err_msg_valid with class err_msg_class (0 correctable, 1 nonfatal, 2 fatal) raises serr_out for exactly the next cycle only if control bit 1 is 1 and rc_err_en[class] is 1; class 3 and all other cases give no pulse.
- R10: A poison_cpl pulse sets status bit 0 on the next edge only when control bit 0 is 1; the bit then holds regardless of bit 0 and is cleared by writing 1 to status bit 0 (writing 0 leaves it).
- R11: hot_rst_req is 1 while control bit 6 is 1 and link_state is 0 (L0), 1 (L0s) or 2 (L1); it is 0 for link_state 3 or when bit 6 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control word, 1 selects status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| win_base_hi | input | 4 | I/O window base, address bits 15:12 |
| win_limit_hi | input | 4 | I/O window limit, address bits 15:12 |
| io_addr | input | 16 | Processor I/O address under decode |
| io_fwd | output | 1 | 1 when the access is sent downstream |
| err_msg_valid | input | 1 | Error message received from downstream |
| err_msg_class | input | 2 | Error class of the message |
| rc_err_en | input | 3 | Per-class enables from root control |
| serr_out | output | 1 | System-error pulse |
| poison_cpl | input | 1 | Poisoned read completion received |
| link_state | input | 2 | Current link state |
| hot_rst_req | output | 1 | Hot-reset request to the link state machine |

## Verification
The bench targets the window edges at 0x?000 and 0x?FFF and an inverted base/limit pair, where an off-by-one or a signed compare would forward one address too many or too few. It walks the 1 KB block boundaries under ISA exclusion, where a wrong bit pair would hold back the lower quarter or pass the upper ones. Display addresses are probed just outside each range and at aliases such as 0x7C0 and 0xF3D5, which a decoder ignoring the full-decode bit, or honouring it with display routing off, would route wrongly. The error gate is driven with a disabled class and the reserved class, and the parity flag with a write of zero, where a loose gate or a plain-write clear would show up.

// File: rtl/brc_pkg.sv
package brc_pkg;
   localparam int CTRL_W      = 16;
   localparam int B_PAR_EN    = 0;
   localparam int B_SERR_EN   = 1;
   localparam int B_ISA_EN    = 2;
   localparam int B_VGA_EN    = 3;
   localparam int B_VGA16     = 4;
   localparam int B_MAM       = 5;
   localparam int B_HOT_RST   = 6;

   typedef enum logic [1:0] {
      LNK_L0    = 2'd0,
      LNK_L0S   = 2'd1,
      LNK_L1    = 2'd2,
      LNK_OTHER = 2'd3
   } link_st_e;
endpackage

// File: rtl/brc_ctrl_reg.sv
module brc_ctrl_reg
   import brc_pkg::*;
#(
   parameter int               W     = CTRL_W,
   parameter logic [W-1:0]     WMASK = 16'h005F
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         sel,
   input  logic [W-1:0] wdata,
   input  logic         poison_in,
   output logic [W-1:0] rdata,
   output logic [W-1:0] ctrl_q,
   output logic         par_flag
);
   generate
      if (W < 7 || WMASK[B_MAM] != 1'b0) begin : g_bad_cfg
         $error("brc_ctrl_reg: width too small or read-only bit made writable");
      end
   endgenerate

   logic par_set, par_clr;

   assign par_set = poison_in && ctrl_q[B_PAR_EN];
   assign par_clr = wr_en && sel && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         par_flag <= 1'b0;
      end else begin
         if (wr_en && !sel) ctrl_q <= wdata & WMASK;
         if (par_set)       par_flag <= 1'b1;
         else if (par_clr)  par_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) rdata[0] = par_flag;
      else     rdata    = ctrl_q;
   end

   p_mam_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> rdata[B_MAM] == 1'b0);

   p_par_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_flag) |-> $past(poison_in && ctrl_q[B_PAR_EN]));

   p_par_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      par_flag && !(wr_en && sel && wdata[0]) |=> par_flag);
endmodule

// File: rtl/brc_io_decode.sv
module brc_io_decode #(
   parameter int ADDR_W    = 16,
   parameter int GRAN_BITS = 12,
   localparam int HI_W     = ADDR_W - GRAN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [HI_W-1:0]   base_hi,
   input  logic [HI_W-1:0]   limit_hi,
   input  logic              isa_en,
   input  logic              vga_en,
   input  logic              vga16,
   output logic              io_fwd
);
   generate
      if (ADDR_W < 11 || GRAN_BITS < 10 || GRAN_BITS >= ADDR_W) begin : g_bad_cfg
         $error("brc_io_decode: unsupported address or granularity width");
      end
   endgenerate

   logic [ADDR_W-1:0] base_eff, limit_eff;
   logic [9:0]        lo10;
   logic              in_win, isa_cut, vga_lo, upper_zero, vga_hit;

   assign base_eff  = {base_hi,  {GRAN_BITS{1'b0}}};
   assign limit_eff = {limit_hi, {GRAN_BITS{1'b1}}};
   assign in_win    = (io_addr >= base_eff) && (io_addr <= limit_eff);
   assign isa_cut   = isa_en && (io_addr[9:8] != 2'b00);
   assign lo10      = io_addr[9:0];
   assign vga_lo    = ((lo10 >= 10'h3B0) && (lo10 <= 10'h3BB)) ||
                      ((lo10 >= 10'h3C0) && (lo10 <= 10'h3DF));

   generate
      if (ADDR_W > 10) begin : g_upper
         assign upper_zero = (io_addr[ADDR_W-1:10] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign vga_hit = vga_en && vga_lo && (!vga16 || upper_zero);
   assign io_fwd  = vga_hit || (in_win && !isa_cut);

   p_isa_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_en && !vga_en && io_addr[9:8] != 2'b00) |-> !io_fwd);

   p_empty_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (base_hi > limit_hi && !vga_en) |-> !io_fwd);

   p_vga_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!vga_en && io_fwd) |-> in_win);
endmodule

// File: rtl/brc_err_gate.sv
module brc_err_gate #(
   parameter int  NUM_CLASS = 3,
   localparam int CLS_W     = (NUM_CLASS > 1) ? $clog2(NUM_CLASS + 1) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 serr_en,
   input  logic                 msg_valid,
   input  logic [CLS_W-1:0]     msg_class,
   input  logic [NUM_CLASS-1:0] class_en,
   output logic                 serr
);
   generate
      if (NUM_CLASS < 1) begin : g_bad_cfg
         $error("brc_err_gate: need at least one error class");
      end
   endgenerate

   logic [NUM_CLASS-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_CLASS; i++) begin : g_cls
         assign hit[i] = msg_valid && (msg_class == CLS_W'(i)) && class_en[i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) serr <= 1'b0;
      else        serr <= serr_en && (|hit);
   end

   p_serr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_en |=> !serr);

   p_serr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> !serr);
endmodule

// File: rtl/brc_io_router.sv
module brc_io_router
   import brc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int GRAN_BITS = 12,
   parameter int NUM_CLASS = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr_en,
   input  logic                        reg_sel,
   input  logic [CTRL_W-1:0]           reg_wdata,
   output logic [CTRL_W-1:0]           reg_rdata,
   input  logic [ADDR_W-GRAN_BITS-1:0] win_base_hi,
   input  logic [ADDR_W-GRAN_BITS-1:0] win_limit_hi,
   input  logic [ADDR_W-1:0]           io_addr,
   output logic                        io_fwd,
   input  logic                        err_msg_valid,
   input  logic [1:0]                  err_msg_class,
   input  logic [NUM_CLASS-1:0]        rc_err_en,
   output logic                        serr_out,
   input  logic                        poison_cpl,
   input  logic [1:0]                  link_state,
   output logic                        hot_rst_req
);
   logic [CTRL_W-1:0] ctrl_q;
   logic              par_flag;

   brc_ctrl_reg #(.W(CTRL_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .poison_in (poison_cpl),
      .rdata     (reg_rdata),
      .ctrl_q    (ctrl_q),
      .par_flag  (par_flag)
   );

   brc_io_decode #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .base_hi  (win_base_hi),
      .limit_hi (win_limit_hi),
      .isa_en   (ctrl_q[B_ISA_EN]),
      .vga_en   (ctrl_q[B_VGA_EN]),
      .vga16    (ctrl_q[B_VGA16]),
      .io_fwd   (io_fwd)
   );

   brc_err_gate #(.NUM_CLASS(NUM_CLASS)) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .serr_en   (ctrl_q[B_SERR_EN]),
      .msg_valid (err_msg_valid),
      .msg_class (err_msg_class),
      .class_en  (rc_err_en),
      .serr      (serr_out)
   );

   assign hot_rst_req = ctrl_q[B_HOT_RST] && (link_state != LNK_OTHER);

   p_hot_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hot_rst_req |-> link_state != LNK_OTHER);

   p_hot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_rst_req && !reg_wr_en && $stable(link_state)) |=> hot_rst_req);
endmodule

// File: tb/brc_io_router_tb_top.sv
module brc_io_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  win_base_hi = '0;
   logic [3:0]  win_limit_hi = '0;
   logic [15:0] io_addr = '0;
   logic        io_fwd;
   logic        err_msg_valid = 1'b0;
   logic [1:0]  err_msg_class = '0;
   logic [2:0]  rc_err_en = '0;
   logic        serr_out;
   logic        poison_cpl = 1'b0;
   logic [1:0]  link_state = '0;
   logic        hot_rst_req;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   brc_io_router dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_base_hi(win_base_hi),
      .win_limit_hi(win_limit_hi), .io_addr(io_addr), .io_fwd(io_fwd),
      .err_msg_valid(err_msg_valid), .err_msg_class(err_msg_class),
      .rc_err_en(rc_err_en), .serr_out(serr_out), .poison_cpl(poison_cpl),
      .link_state(link_state), .hot_rst_req(hot_rst_req)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic sel, input logic [15:0] exp);
      reg_sel = sel;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic fwd_chk(input string tag, input logic [15:0] a, input logic exp);
      io_addr = a;
      #1;
      chk($sformatf("%s addr %h", tag, a), {15'd0, io_fwd}, {15'd0, exp});
   endtask

   task automatic t_reset();
      rd_chk("R1 ctrl reset", 1'b0, 16'h0000);
      rd_chk("R1 status reset", 1'b1, 16'h0000);
   endtask

   task automatic t_mask();
      wr(1'b0, 16'hFFFF);
      rd_chk("R1 writable mask, bit5 zero", 1'b0, 16'h005F);
      wr(1'b0, 16'h0020);
      rd_chk("R1 bit5 read-only", 1'b0, 16'h0000);
   endtask

   task automatic t_window();
      wr(1'b0, 16'h0000);
      win_base_hi = 4'h1; win_limit_hi = 4'h2;
      fwd_chk("R2 low edge", 16'h1000, 1'b1);
      fwd_chk("R2 high edge", 16'h2FFF, 1'b1);
      fwd_chk("R2 below", 16'h0FFF, 1'b0);
      fwd_chk("R2 above", 16'h3000, 1'b0);
      fwd_chk("R2 upper quarter no ISA", 16'h1300, 1'b1);
   endtask

   task automatic t_empty();
      win_base_hi = 4'h3; win_limit_hi = 4'h2;
      fwd_chk("R3 inverted", 16'h2800, 1'b0);
      fwd_chk("R3 inverted", 16'h3000, 1'b0);
      win_base_hi = 4'h5; win_limit_hi = 4'h5;
      fwd_chk("R3 single block", 16'h5000, 1'b1);
      fwd_chk("R3 single block", 16'h5FFF, 1'b1);
      fwd_chk("R3 single block", 16'h6000, 1'b0);
   endtask

   task automatic t_isa();
      wr(1'b0, 16'h0004);
      win_base_hi = 4'h1; win_limit_hi = 4'h2;
      fwd_chk("R4 first quarter", 16'h1000, 1'b1);
      fwd_chk("R4 first quarter end", 16'h10FF, 1'b1);
      fwd_chk("R4 cut start", 16'h1100, 1'b0);
      fwd_chk("R4 cut end", 16'h13FF, 1'b0);
      fwd_chk("R4 next block", 16'h1400, 1'b1);
      fwd_chk("R4 outside", 16'h0000, 1'b0);
   endtask

   task automatic t_vga();
      win_base_hi = 4'h8; win_limit_hi = 4'h7;
      wr(1'b0, 16'h0000);
      fwd_chk("R5 vga off", 16'h03C0, 1'b0);
      wr(1'b0, 16'h0010);
      fwd_chk("R8 vga16 alone", 16'h03C0, 1'b0);
      fwd_chk("R8 vga16 alone", 16'h03B0, 1'b0);
      wr(1'b0, 16'h0008);
      fwd_chk("R6 range1 start", 16'h03B0, 1'b1);
      fwd_chk("R6 range1 end", 16'h03BB, 1'b1);
      fwd_chk("R6 gap", 16'h03BC, 1'b0);
      fwd_chk("R6 range2 end", 16'h03DF, 1'b1);
      fwd_chk("R6 past range2", 16'h03E0, 1'b0);
      fwd_chk("R6 alias", 16'h07C0, 1'b1);
      fwd_chk("R6 alias", 16'hF3D5, 1'b1);
      wr(1'b0, 16'h0018);
      fwd_chk("R7 exact", 16'h03C0, 1'b1);
      fwd_chk("R7 exact", 16'h03B5, 1'b1);
      fwd_chk("R7 alias rejected", 16'h07C0, 1'b0);
      fwd_chk("R7 alias rejected", 16'hF3D5, 1'b0);
      wr(1'b0, 16'h000C);
      win_base_hi = 4'h0; win_limit_hi = 4'h0;
      fwd_chk("R6 overrides ISA cut", 16'h03C0, 1'b1);
      fwd_chk("R4 non-vga cut", 16'h03E0, 1'b0);
   endtask

   task automatic send_err(input string tag, input logic [1:0] cls, input logic exp);
      @(negedge clk);
      err_msg_valid = 1'b1; err_msg_class = cls;
      @(negedge clk);
      err_msg_valid = 1'b0;
      chk({tag, " pulse"}, {15'd0, serr_out}, {15'd0, exp});
      @(negedge clk);
      chk({tag, " one cycle"}, {15'd0, serr_out}, 16'd0);
   endtask

   task automatic t_serr();
      wr(1'b0, 16'h0002);
      rc_err_en = 3'b111;
      send_err("R9 correctable", 2'd0, 1'b1);
      send_err("R9 fatal", 2'd2, 1'b1);
      send_err("R9 reserved class", 2'd3, 1'b0);
      rc_err_en = 3'b101;
      send_err("R9 class disabled", 2'd1, 1'b0);
      wr(1'b0, 16'h0000);
      rc_err_en = 3'b111;
      send_err("R9 serr off", 2'd2, 1'b0);
   endtask

   task automatic poison();
      @(negedge clk);
      poison_cpl = 1'b1;
      @(negedge clk);
      poison_cpl = 1'b0;
   endtask

   task automatic t_parity();
      wr(1'b0, 16'h0000);
      poison();
      rd_chk("R10 gated off", 1'b1, 16'h0000);
      wr(1'b0, 16'h0001);
      poison();
      rd_chk("R10 set", 1'b1, 16'h0001);
      wr(1'b0, 16'h0000);
      rd_chk("R10 sticky", 1'b1, 16'h0001);
      wr(1'b1, 16'h0000);
      rd_chk("R10 write 0 keeps", 1'b1, 16'h0001);
      wr(1'b1, 16'h0001);
      rd_chk("R10 write 1 clears", 1'b1, 16'h0000);
   endtask

   task automatic t_hot();
      wr(1'b0, 16'h0040);
      for (int s = 0; s < 4; s++) begin
         link_state = 2'(s);
         #1;
         chk($sformatf("R11 link state %0d", s), {15'd0, hot_rst_req}, {15'd0, (s != 3)});
      end
      link_state = 2'd0;
      repeat (3) @(negedge clk);
      chk("R11 held", {15'd0, hot_rst_req}, 16'd1);
      wr(1'b0, 16'h0000);
      chk("R11 released", {15'd0, hot_rst_req}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_window();
      t_empty();
      t_isa();
      t_vga();
      t_serr();
      t_parity();
      t_hot();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule